// File: doc/BRIEF.md
# Ternary Match Table with Lowest-Index Priority

This block is a small lookup table whose entries are found by content. Each slot keeps a comparison word, a per-bit wildcard word, an associated result word and a live flag. When a key is presented, every live slot is compared with it at once. Any bit whose wildcard is set is left out of the comparison. The slots that agree are reduced to one winner, the one with the smallest slot number. The winner's number and its associated word are returned on the clock edge that follows the request.

A second, address-driven port lets a host fill, overwrite, invalidate and read back individual slots, much like a plain SRAM. This port does not use the comparators. A common use is a longest-prefix route lookup on 32-bit addresses. Longer prefixes are placed in lower slots, so the lowest-index rule yields the most specific route.

Top module: `tcam_lookup`

## Requirements
- R1: Each slot holds a KEY_W-bit pattern and a KEY_W-bit wildcard word; wildcard bit n = 1 makes key bit n irrelevant to that slot, wildcard bit n = 0 requires key bit n to equal pattern bit n.
- R2: A slot matches only when its live flag is 1 and every non-wildcard bit agrees with the key; a slot with the live flag at 0 never matches.
- R3: When several slots match, `hit_index` reports the smallest matching slot number, as an unsigned binary value.
- R4: `result_valid` is 1 exactly in the cycle after a cycle with `key_valid` = 1, and 0 after a cycle with `key_valid` = 0; the result reflects the key sampled on that edge.
- R5: When no slot matches, or no search was made, `hit` is 0 and both `hit_index` and `hit_assoc` are 0.
- R6: On a hit, `hit_assoc` carries the associated word stored in the winning slot.
- R7: A cycle with `wr_en` = 1 writes pattern, wildcard, associated word and live flag (`wr_live`) into slot `wr_addr`; writing `wr_live` = 0 removes the slot from every later search.
- R8: A cycle with `rd_en` = 1 returns the pattern, wildcard, associated word and live flag of slot `rd_addr` on the next cycle, with `rd_ack` = 1 in that cycle only.
- R9: A search or read in the same cycle as a write sees the table as it was before that write.
- R10: Reset clears every live flag, so no search hits and every slot reads back as not live until it is written.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| key_valid | input | 1 | Search request this cycle |
| key | input | KEY_W | Search key |
| result_valid | output | 1 | Search result present this cycle |
| hit | output | 1 | At least one slot matched |
| hit_index | output | IDX_W | Lowest matching slot number |
| hit_assoc | output | ASSOC_W | Associated word of the winning slot |
| wr_en | input | 1 | Write slot this cycle |
| wr_addr | input | IDX_W | Slot to write |
| wr_pattern | input | KEY_W | Pattern to store |
| wr_wild | input | KEY_W | Wildcard word to store (1 = don't care) |
| wr_assoc | input | ASSOC_W | Associated word to store |
| wr_live | input | 1 | Live flag to store |
| rd_en | input | 1 | Read slot this cycle |
| rd_addr | input | IDX_W | Slot to read |
| rd_ack | output | 1 | Read data present this cycle |
| rd_pattern | output | KEY_W | Pattern read back |
| rd_wild | output | KEY_W | Wildcard word read back |
| rd_assoc | output | ASSOC_W | Associated word read back |
| rd_live | output | 1 | Live flag read back |

## Verification
A corrupted pattern or wildcard bit shows as a wrong winner or a missed hit on the first search that touches that bit position. It also shows in the read-back of that slot one cycle after the read request. A stuck or lost live flag changes the hit or miss outcome of the next search aimed at that slot. A faulty priority reduction reports a higher slot than the lowest matching one in the result cycle itself. The vectors place overlapping prefixes in adjacent slots so that each of these faults changes a visible index or associated word.

// File: rtl/tcam_pkg.sv
package tcam_pkg;
    localparam int unsigned KEY_W_DEFAULT   = 32;
    localparam int unsigned DEPTH_DEFAULT   = 16;
    localparam int unsigned ASSOC_W_DEFAULT = 8;

    function automatic int unsigned index_width(input int unsigned depth);
        return (depth > 1) ? $clog2(depth) : 1;
    endfunction
endpackage

// File: rtl/tcam_store.sv
module tcam_store #(
    parameter int unsigned KEY_W   = 32,
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned ASSOC_W = 8,
    parameter int unsigned IDX_W   = 4
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            wr_en,
    input  logic [IDX_W-1:0]                wr_addr,
    input  logic [KEY_W-1:0]                wr_pattern,
    input  logic [KEY_W-1:0]                wr_wild,
    input  logic [ASSOC_W-1:0]              wr_assoc,
    input  logic                            wr_live,
    input  logic                            rd_en,
    input  logic [IDX_W-1:0]                rd_addr,
    output logic [DEPTH-1:0][KEY_W-1:0]     tbl_pattern,
    output logic [DEPTH-1:0][KEY_W-1:0]     tbl_wild,
    output logic [DEPTH-1:0][ASSOC_W-1:0]   tbl_assoc,
    output logic [DEPTH-1:0]                tbl_live,
    output logic                            rd_ack,
    output logic [KEY_W-1:0]                rd_pattern,
    output logic [KEY_W-1:0]                rd_wild,
    output logic [ASSOC_W-1:0]              rd_assoc,
    output logic                            rd_live
);
    typedef struct packed {
        logic [DEPTH-1:0][KEY_W-1:0]   pattern;
        logic [DEPTH-1:0][KEY_W-1:0]   wild;
        logic [DEPTH-1:0][ASSOC_W-1:0] assoc;
        logic [DEPTH-1:0]              live;
        logic                          ack;
        logic [KEY_W-1:0]              r_pattern;
        logic [KEY_W-1:0]              r_wild;
        logic [ASSOC_W-1:0]            r_assoc;
        logic                          r_live;
    } store_t;

    store_t st_d, st_q;

    always_comb begin
        st_d     = st_q;
        st_d.ack = rd_en;
        // Read samples the current contents, so a same-cycle write is not seen.
        if (rd_en) begin
            st_d.r_pattern = st_q.pattern[rd_addr];
            st_d.r_wild    = st_q.wild[rd_addr];
            st_d.r_assoc   = st_q.assoc[rd_addr];
            st_d.r_live    = st_q.live[rd_addr];
        end
        if (wr_en) begin
            st_d.pattern[wr_addr] = wr_pattern;
            st_d.wild[wr_addr]    = wr_wild;
            st_d.assoc[wr_addr]   = wr_assoc;
            st_d.live[wr_addr]    = wr_live;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign tbl_pattern = st_q.pattern;
    assign tbl_wild    = st_q.wild;
    assign tbl_assoc   = st_q.assoc;
    assign tbl_live    = st_q.live;
    assign rd_ack      = st_q.ack;
    assign rd_pattern  = st_q.r_pattern;
    assign rd_wild     = st_q.r_wild;
    assign rd_assoc    = st_q.r_assoc;
    assign rd_live     = st_q.r_live;
endmodule

// File: rtl/tcam_compare.sv
module tcam_compare #(
    parameter int unsigned KEY_W = 32,
    parameter int unsigned DEPTH = 16
) (
    input  logic [KEY_W-1:0]            key,
    input  logic [DEPTH-1:0][KEY_W-1:0] tbl_pattern,
    input  logic [DEPTH-1:0][KEY_W-1:0] tbl_wild,
    input  logic [DEPTH-1:0]            tbl_live,
    output logic [DEPTH-1:0]            match_vec
);
    for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
        logic [KEY_W-1:0] diff;
        assign diff          = (tbl_pattern[gi] ^ key) & ~tbl_wild[gi];
        assign match_vec[gi] = tbl_live[gi] && (diff == '0);
    end
endmodule

// File: rtl/tcam_prio.sv
module tcam_prio #(
    parameter int unsigned DEPTH = 16,
    parameter int unsigned IDX_W = 4
) (
    input  logic [DEPTH-1:0] match_vec,
    output logic             any_match,
    output logic [IDX_W-1:0] win_idx
);
    always_comb begin
        any_match = 1'b0;
        win_idx   = '0;
        // Scan downwards so the lowest set position is the last assignment.
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (match_vec[i]) begin
                any_match = 1'b1;
                win_idx   = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tcam_lookup.sv
module tcam_lookup import tcam_pkg::*; #(
    parameter int unsigned KEY_W   = KEY_W_DEFAULT,
    parameter int unsigned DEPTH   = DEPTH_DEFAULT,
    parameter int unsigned ASSOC_W = ASSOC_W_DEFAULT,
    parameter int unsigned IDX_W   = index_width(DEPTH)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               key_valid,
    input  logic [KEY_W-1:0]   key,
    output logic               result_valid,
    output logic               hit,
    output logic [IDX_W-1:0]   hit_index,
    output logic [ASSOC_W-1:0] hit_assoc,
    input  logic               wr_en,
    input  logic [IDX_W-1:0]   wr_addr,
    input  logic [KEY_W-1:0]   wr_pattern,
    input  logic [KEY_W-1:0]   wr_wild,
    input  logic [ASSOC_W-1:0] wr_assoc,
    input  logic               wr_live,
    input  logic               rd_en,
    input  logic [IDX_W-1:0]   rd_addr,
    output logic               rd_ack,
    output logic [KEY_W-1:0]   rd_pattern,
    output logic [KEY_W-1:0]   rd_wild,
    output logic [ASSOC_W-1:0] rd_assoc,
    output logic               rd_live
);
    logic [DEPTH-1:0][KEY_W-1:0]   tbl_pattern;
    logic [DEPTH-1:0][KEY_W-1:0]   tbl_wild;
    logic [DEPTH-1:0][ASSOC_W-1:0] tbl_assoc;
    logic [DEPTH-1:0]              tbl_live;
    logic [DEPTH-1:0]              match_vec;
    logic                          any_match;
    logic [IDX_W-1:0]              win_idx;

    tcam_store #(.KEY_W(KEY_W), .DEPTH(DEPTH), .ASSOC_W(ASSOC_W), .IDX_W(IDX_W)) u_store (
        .clk        (clk),
        .rst_n      (rst_n),
        .wr_en      (wr_en),
        .wr_addr    (wr_addr),
        .wr_pattern (wr_pattern),
        .wr_wild    (wr_wild),
        .wr_assoc   (wr_assoc),
        .wr_live    (wr_live),
        .rd_en      (rd_en),
        .rd_addr    (rd_addr),
        .tbl_pattern(tbl_pattern),
        .tbl_wild   (tbl_wild),
        .tbl_assoc  (tbl_assoc),
        .tbl_live   (tbl_live),
        .rd_ack     (rd_ack),
        .rd_pattern (rd_pattern),
        .rd_wild    (rd_wild),
        .rd_assoc   (rd_assoc),
        .rd_live    (rd_live)
    );

    tcam_compare #(.KEY_W(KEY_W), .DEPTH(DEPTH)) u_cmp (
        .key        (key),
        .tbl_pattern(tbl_pattern),
        .tbl_wild   (tbl_wild),
        .tbl_live   (tbl_live),
        .match_vec  (match_vec)
    );

    tcam_prio #(.DEPTH(DEPTH), .IDX_W(IDX_W)) u_prio (
        .match_vec(match_vec),
        .any_match(any_match),
        .win_idx  (win_idx)
    );

    typedef struct packed {
        logic               valid;
        logic               hit;
        logic [IDX_W-1:0]   idx;
        logic [ASSOC_W-1:0] assoc;
    } result_t;

    result_t res_d, res_q;

    always_comb begin
        res_d       = '0;
        res_d.valid = key_valid;
        if (key_valid && any_match) begin
            res_d.hit   = 1'b1;
            res_d.idx   = win_idx;
            res_d.assoc = tbl_assoc[win_idx];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) res_q <= '0;
        else        res_q <= res_d;
    end

    assign result_valid = res_q.valid;
    assign hit          = res_q.hit;
    assign hit_index    = res_q.idx;
    assign hit_assoc    = res_q.assoc;
endmodule

// File: rtl/tcam_lookup_chk.sv
module tcam_lookup_chk #(
    parameter int unsigned DEPTH   = 16,
    parameter int unsigned ASSOC_W = 8,
    parameter int unsigned IDX_W   = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               key_valid,
    input logic               rd_en,
    input logic               result_valid,
    input logic               hit,
    input logic [IDX_W-1:0]   hit_index,
    input logic [ASSOC_W-1:0] hit_assoc,
    input logic               rd_ack,
    input logic [DEPTH-1:0]   match_vec
);
    logic [DEPTH-1:0] match_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) match_q <= '0;
        else        match_q <= match_vec;
    end

    a_r4_result_follows_key: assert property (@(posedge clk) disable iff (!rst_n)
        key_valid |=> result_valid);
    a_r4_no_spurious_result: assert property (@(posedge clk) disable iff (!rst_n)
        !key_valid |=> !result_valid);
    a_r5_miss_outputs_zero: assert property (@(posedge clk) disable iff (!rst_n)
        !hit |-> (hit_index == '0 && hit_assoc == '0));
    a_r5_hit_only_with_result: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> result_valid);
    a_r2_winner_matched: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> match_q[hit_index]);
    a_r3_lowest_wins: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> ((match_q & ((DEPTH'(1) << hit_index) - DEPTH'(1))) == '0));
    a_r3_match_gives_hit: assert property (@(posedge clk) disable iff (!rst_n)
        (result_valid && (match_q != '0)) |-> hit);
    a_r8_read_ack: assert property (@(posedge clk) disable iff (!rst_n)
        rd_en |=> rd_ack);
    a_r8_no_stray_ack: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> !rd_ack);
endmodule

bind tcam_lookup tcam_lookup_chk #(.DEPTH(DEPTH), .ASSOC_W(ASSOC_W), .IDX_W(IDX_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .key_valid   (key_valid),
    .rd_en       (rd_en),
    .result_valid(result_valid),
    .hit         (hit),
    .hit_index   (hit_index),
    .hit_assoc   (hit_assoc),
    .rd_ack      (rd_ack),
    .match_vec   (match_vec)
);

// File: tb/sim_tcam_lookup.sv
module sim_tcam_lookup;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        key_valid = 1'b0;
    logic [31:0] key = '0;
    logic        result_valid, hit;
    logic [3:0]  hit_index;
    logic [7:0]  hit_assoc;
    logic        wr_en = 1'b0;
    logic [3:0]  wr_addr = '0;
    logic [31:0] wr_pattern = '0, wr_wild = '0;
    logic [7:0]  wr_assoc = '0;
    logic        wr_live = 1'b0;
    logic        rd_en = 1'b0;
    logic [3:0]  rd_addr = '0;
    logic        rd_ack;
    logic [31:0] rd_pattern, rd_wild;
    logic [7:0]  rd_assoc;
    logic        rd_live;

    int n_run = 0;
    int n_fail = 0;

    always #(CLK_PERIOD / 2) clk = ~clk;

    tcam_lookup u0 (
        .clk(clk), .rst_n(rst_n), .key_valid(key_valid), .key(key),
        .result_valid(result_valid), .hit(hit), .hit_index(hit_index), .hit_assoc(hit_assoc),
        .wr_en(wr_en), .wr_addr(wr_addr), .wr_pattern(wr_pattern), .wr_wild(wr_wild),
        .wr_assoc(wr_assoc), .wr_live(wr_live), .rd_en(rd_en), .rd_addr(rd_addr),
        .rd_ack(rd_ack), .rd_pattern(rd_pattern), .rd_wild(rd_wild), .rd_assoc(rd_assoc),
        .rd_live(rd_live)
    );

    typedef struct packed {
        logic [31:0] key;
        logic        hit;
        logic [3:0]  idx;
        logic [7:0]  assoc;
    } vec_t;

    // Table: 0 = 10.1.2.3/32, 1 = 10.1.2.0/24, 2 = 10.1.0.0/16, 3 = 10.0.0.0/8,
    // 4 = 192.168.0.0/16, 5 = any key with bits 7:4 all ones.
    localparam vec_t VECS [9] = '{
        '{32'h0A01_0203, 1'b1, 4'd0, 8'h11},
        '{32'h0A01_0204, 1'b1, 4'd1, 8'h22},
        '{32'h0A01_FF00, 1'b1, 4'd2, 8'h33},
        '{32'h0A7F_0001, 1'b1, 4'd3, 8'h44},
        '{32'hC0A8_0505, 1'b1, 4'd4, 8'h55},
        '{32'h1234_56F7, 1'b1, 4'd5, 8'h66},
        '{32'h0B00_0000, 1'b0, 4'd0, 8'h00},
        '{32'hC0A9_00F0, 1'b1, 4'd5, 8'h66},
        '{32'h0A01_02F3, 1'b1, 4'd1, 8'h22}
    };

    task automatic check(input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [3:0] a, input logic [31:0] p, input logic [31:0] w,
                       input logic [7:0] s, input logic lv);
        wr_en = 1'b1; wr_addr = a; wr_pattern = p; wr_wild = w; wr_assoc = s; wr_live = lv;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic look(input logic [31:0] k);
        key_valid = 1'b1; key = k;
        @(negedge clk);
        key_valid = 1'b0;
    endtask

    task automatic fetch(input logic [3:0] a);
        rd_en = 1'b1; rd_addr = a;
        @(negedge clk);
        rd_en = 1'b0;
    endtask

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        $display("FAIL watchdog actual=timeout expected=done");
        n_fail++;
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        check("R4 reset result_valid", 64'(result_valid), 64'd0);
        check("R5 reset hit", 64'(hit), 64'd0);
        rst_n = 1'b1;
        @(negedge clk);

        // R10: slots have pattern 0 but are not live after reset
        look(32'h0000_0000);
        check("R10 no hit after reset", 64'(hit), 64'd0);
        check("R4 result_valid after search", 64'(result_valid), 64'd1);
        fetch(4'd0);
        check("R10 read live after reset", 64'(rd_live), 64'd0);
        check("R8 rd_ack", 64'(rd_ack), 64'd1);

        put(4'd0, 32'h0A01_0203, 32'h0000_0000, 8'h11, 1'b1);
        put(4'd1, 32'h0A01_0200, 32'h0000_00FF, 8'h22, 1'b1);
        put(4'd2, 32'h0A01_0000, 32'h0000_FFFF, 8'h33, 1'b1);
        put(4'd3, 32'h0A00_0000, 32'h00FF_FFFF, 8'h44, 1'b1);
        put(4'd4, 32'hC0A8_0000, 32'h0000_FFFF, 8'h55, 1'b1);
        put(4'd5, 32'h0000_00F0, 32'hFFFF_FF0F, 8'h66, 1'b1);
        check("R4 idle result_valid", 64'(result_valid), 64'd0);
        check("R8 rd_ack single cycle", 64'(rd_ack), 64'd0);

        // R1 R2 R3 R6 vector walk
        foreach (VECS[i]) begin
            look(VECS[i].key);
            check($sformatf("R4 vec%0d valid", i), 64'(result_valid), 64'd1);
            check($sformatf("R3 R1 vec%0d hit", i), 64'(hit), 64'(VECS[i].hit));
            check($sformatf("R3 vec%0d index", i), 64'(hit_index), 64'(VECS[i].idx));
            check($sformatf("R6 R5 vec%0d assoc", i), 64'(hit_assoc), 64'(VECS[i].assoc));
        end

        // R8 read back of slot 4
        fetch(4'd4);
        check("R8 read pattern", 64'(rd_pattern), 64'h0000_0000_C0A8_0000);
        check("R8 read wild", 64'(rd_wild), 64'h0000_0000_0000_FFFF);
        check("R8 read assoc", 64'(rd_assoc), 64'h55);
        check("R8 read live", 64'(rd_live), 64'd1);

        // R7 invalidate slot 0
        put(4'd0, 32'h0A01_0203, 32'h0000_0000, 8'h11, 1'b0);
        look(32'h0A01_0203);
        check("R7 R2 invalid slot skipped", 64'(hit_index), 64'd1);
        check("R7 assoc after invalidate", 64'(hit_assoc), 64'h22);

        // R9 write and search in the same cycle: search sees old table
        wr_en = 1'b1; wr_addr = 4'd0; wr_pattern = 32'h0A01_0203; wr_wild = '0;
        wr_assoc = 8'h77; wr_live = 1'b1;
        key_valid = 1'b1; key = 32'h0A01_0203;
        rd_en = 1'b1; rd_addr = 4'd0;
        @(negedge clk);
        wr_en = 1'b0; key_valid = 1'b0; rd_en = 1'b0;
        check("R9 search sees old table", 64'(hit_index), 64'd1);
        check("R9 read sees old live", 64'(rd_live), 64'd0);
        look(32'h0A01_0203);
        check("R9 R7 new write visible", 64'(hit_index), 64'd0);
        check("R6 new assoc", 64'(hit_assoc), 64'h77);

        // R5 miss then R1 default route in highest slot
        look(32'h0B00_0000);
        check("R5 miss hit", 64'(hit), 64'd0);
        check("R5 miss index", 64'(hit_index), 64'd0);
        put(4'd15, 32'h0000_0000, 32'hFFFF_FFFF, 8'hEE, 1'b1);
        look(32'h0B00_0000);
        check("R1 full wildcard index", 64'(hit_index), 64'd15);
        check("R6 full wildcard assoc", 64'(hit_assoc), 64'hEE);
        look(32'hC0A8_0001);
        check("R3 lower slot beats default", 64'(hit_index), 64'd4);

        finish_run();
    end
endmodule